// File: doc/BRIEF.md
# Fuel-Gauge Register Bank with Software Reset Sequencing

This block is the host-visible register file of a battery fuel-gauge controller. A host reaches it over a plain parallel bus: an 8-bit address, 8-bit write data, a write strobe sampled on the clock edge, and read data that follows the address combinationally. Next to the ordinary storage registers it holds a few registers with behaviour of their own. One is an over-voltage limit that is compared with the digitized stack voltage to pull a charge-control output low. Another is a saturating high-byte discharge counter. There are also sticky charge and discharge event flags, and a constant identification byte.

The bank also watches for a two-write software reset. The host writes zero to the full-count register and then, with no other write in between, writes zero to the learned-capacity register. On that second write the bank reloads a defined mix of fields instead of storing the write. Some fields are cleared, two status flags are set, and the full-count and learned-capacity registers are reloaded from the programmed full count (parameter `PROG_FULL`). A one-cycle pulse then marks the event. Pulse events, the end-of-discharge flag and the voltage sample come in as plain inputs.

Top module: `gauge_regbank`

## Requirements
- R1: The limit register at address 15h reads 00h after reset and holds the last byte the host wrote there; nothing else loads it except a software reset.
- R2: With limit byte N, `chg_ctl_n` is low exactly when N is not 00h and `stack_v` is greater, as unsigned, than (256 - N) mod 256. A limit of 00h keeps `chg_ctl_n` high.
- R3: The discharge counter at address 18h is read-only. `dchg_start` clears it to 00h and takes priority over counting. Otherwise each cycle with `dchg_pulse` high adds one.
- R4: The discharge counter stops at FFh and never wraps to 00h.
- R5: While `edv1` is high the discharge counter does not count.
- R6: The flag register at 38h has bit 0 set by `chg_pulse` and bit 3 set by `dchg_pulse`, and its other bits read 0. A set flag stays set until the host writes a 0 to that bit position. Writing a 1 has no effect. A pulse in the same cycle as a clearing write leaves the flag set.
- R7: Address 3Fh always reads FFh, and writes to it have no effect.
- R8: Address 39h reads 00h. A write of any value there changes no register and does not start a software reset.
- R9: A software reset fires on a write of 00h to address 0Ch, provided the write just before it, with no other write between, was 00h to address 2Eh. `soft_rst` is high for the one cycle that follows.
- R10: Any other write between the two sequence writes cancels the sequence. This includes a nonzero write to 2Eh or 0Ch. A later 00h write to 0Ch is then stored as data and does not reset.
- R11: A software reset loads `PROG_FULL` into the full-count register (2Eh) and the learned-capacity register (0Ch). It clears the limit register (15h), the capacity register (02h) and the correction register (0Eh). It sets status bits 0 and 1 of address 0Ah, so that register reads 03h. The discharge counter and the flag register keep their values.
- R12: Power-on reset (`rst_n` low) sets the same values as R11, and also clears the discharge counter and the flag register.
- R13: Addresses outside the map read 00h, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| bus_addr | input | 8 | Host register address |
| bus_wdata | input | 8 | Host write data |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| stack_v | input | 8 | Digitized stack voltage sample |
| chg_pulse | input | 1 | One counted charge pulse |
| dchg_pulse | input | 1 | One counted discharge pulse |
| dchg_start | input | 1 | Start of a valid discharge cycle |
| edv1 | input | 1 | First end-of-discharge flag |
| chg_ctl_n | output | 1 | Charge control, low on over-voltage |
| soft_rst | output | 1 | One-cycle pulse after a software reset |

## Verification
The hardest cases to reach are those where the reset sequence is broken at exactly the right moment. Examples are an aborted sequence followed by a zero write to 0Ch, and a clear of a flag in the same cycle as the event that sets it. The random stimulus picks the two sequence addresses far more often than the others and makes one write in three a zero, so both complete and interrupted sequences occur many times. Directed runs add the threshold boundary on both sides, counter saturation after more than 255 pulses, and a count frozen by `edv1`.

// File: rtl/gauge_regbank.sv
module gauge_regbank #(
  parameter logic [7:0] PROG_FULL = 8'hA5,
  parameter logic [7:0] A_LIMIT   = 8'h15,
  parameter logic [7:0] A_DCNT    = 8'h18,
  parameter logic [7:0] A_FLAGS   = 8'h38,
  parameter logic [7:0] A_RSTREG  = 8'h39,
  parameter logic [7:0] A_ID      = 8'h3F,
  parameter logic [7:0] A_FULL    = 8'h2E,
  parameter logic [7:0] A_LCAP    = 8'h0C,
  parameter logic [7:0] A_CAP     = 8'h02,
  parameter logic [7:0] A_CORR    = 8'h0E,
  parameter logic [7:0] A_STAT    = 8'h0A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_we,
  output logic [7:0] bus_rdata,
  input  logic [7:0] stack_v,
  input  logic       chg_pulse,
  input  logic       dchg_pulse,
  input  logic       dchg_start,
  input  logic       edv1,
  output logic       chg_ctl_n,
  output logic       soft_rst
);
  localparam logic [7:0] ID_VALUE = 8'hFF;
  localparam logic [7:0] CNT_MAX  = 8'hFF;

  logic [7:0] limit_q, full_q, lcap_q, cap_q, corr_q, dcnt_q;
  logic [1:0] stat_q;
  logic       flag_chg_q, flag_dchg_q, armed_q;

  wire wr_zero   = bus_we && (bus_wdata == 8'h00);
  wire seq_fire  = wr_zero && (bus_addr == A_LCAP) && armed_q;
  wire flag_wr   = bus_we && (bus_addr == A_FLAGS);
  wire [7:0] limit_abs = 8'(~limit_q + 8'd1);

  assign chg_ctl_n = !((limit_q != 8'h00) && (stack_v > limit_abs));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q  <= 8'h00;
      full_q   <= PROG_FULL;
      lcap_q   <= PROG_FULL;
      cap_q    <= 8'h00;
      corr_q   <= 8'h00;
      stat_q   <= 2'b11;
      armed_q  <= 1'b0;
      soft_rst <= 1'b0;
    end else begin
      soft_rst <= seq_fire;
      if (seq_fire) begin
        limit_q <= 8'h00;
        full_q  <= PROG_FULL;
        lcap_q  <= PROG_FULL;
        cap_q   <= 8'h00;
        corr_q  <= 8'h00;
        stat_q  <= 2'b11;
        armed_q <= 1'b0;
      end else if (bus_we) begin
        armed_q <= wr_zero && (bus_addr == A_FULL);
        if (bus_addr == A_LIMIT) limit_q <= bus_wdata;
        if (bus_addr == A_FULL)  full_q  <= bus_wdata;
        if (bus_addr == A_LCAP)  lcap_q  <= bus_wdata;
        if (bus_addr == A_CAP)   cap_q   <= bus_wdata;
        if (bus_addr == A_CORR)  corr_q  <= bus_wdata;
        if (bus_addr == A_STAT)  stat_q  <= bus_wdata[1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q      <= 8'h00;
      flag_chg_q  <= 1'b0;
      flag_dchg_q <= 1'b0;
    end else begin
      if (dchg_start)
        dcnt_q <= 8'h00;
      else if (dchg_pulse && !edv1 && dcnt_q != CNT_MAX)
        dcnt_q <= dcnt_q + 8'd1;
      flag_chg_q  <= chg_pulse  || (flag_chg_q  && !(flag_wr && !bus_wdata[0]));
      flag_dchg_q <= dchg_pulse || (flag_dchg_q && !(flag_wr && !bus_wdata[3]));
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    case (bus_addr)
      A_LIMIT: bus_rdata = limit_q;
      A_DCNT:  bus_rdata = dcnt_q;
      A_FLAGS: bus_rdata = {4'b0000, flag_dchg_q, 2'b00, flag_chg_q};
      A_ID:    bus_rdata = ID_VALUE;
      A_FULL:  bus_rdata = full_q;
      A_LCAP:  bus_rdata = lcap_q;
      A_CAP:   bus_rdata = cap_q;
      A_CORR:  bus_rdata = corr_q;
      A_STAT:  bus_rdata = {6'b000000, stat_q};
      default: bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/gauge_regbank_chk.sv
module gauge_regbank_chk #(
  parameter logic [7:0] PROG_FULL = 8'hA5,
  parameter logic [7:0] A_FLAGS   = 8'h38,
  parameter logic [7:0] A_RSTREG  = 8'h39,
  parameter logic [7:0] A_FULL    = 8'h2E
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       bus_we,
  input logic       dchg_start,
  input logic       edv1,
  input logic       chg_ctl_n,
  input logic       soft_rst,
  input logic [7:0] limit_q,
  input logic [7:0] full_q,
  input logic [7:0] lcap_q,
  input logic [7:0] cap_q,
  input logic [7:0] corr_q,
  input logic [1:0] stat_q,
  input logic [7:0] dcnt_q,
  input logic       flag_chg_q,
  input logic       armed_q
);
  AST_LIMIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    limit_q == 8'h00 |-> chg_ctl_n); // R2
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    dchg_start |=> dcnt_q == 8'h00); // R3
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt_q == 8'hFF && !dchg_start |=> dcnt_q == 8'hFF); // R4
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    edv1 && !dchg_start |=> $stable(dcnt_q)); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_chg_q && !(bus_we && bus_addr == A_FLAGS && !bus_wdata[0]) |=> flag_chg_q); // R6
  AST_RSTREG_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == A_RSTREG |=> $stable(limit_q) && $stable(full_q) && $stable(lcap_q)
      && $stable(cap_q) && $stable(corr_q) && $stable(stat_q) && !soft_rst); // R8
  AST_SEQ_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && !(bus_addr == A_FULL && bus_wdata == 8'h00) |=> !armed_q); // R10
  AST_SOFT_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> limit_q == 8'h00 && cap_q == 8'h00 && corr_q == 8'h00 && stat_q == 2'b11
      && lcap_q == PROG_FULL && full_q == PROG_FULL); // R11
endmodule

bind gauge_regbank gauge_regbank_chk #(
  .PROG_FULL(PROG_FULL), .A_FLAGS(A_FLAGS), .A_RSTREG(A_RSTREG), .A_FULL(A_FULL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
  .dchg_start(dchg_start), .edv1(edv1), .chg_ctl_n(chg_ctl_n), .soft_rst(soft_rst),
  .limit_q(limit_q), .full_q(full_q), .lcap_q(lcap_q), .cap_q(cap_q), .corr_q(corr_q),
  .stat_q(stat_q), .dcnt_q(dcnt_q), .flag_chg_q(flag_chg_q), .armed_q(armed_q)
);

// File: tb/tb_gauge_regbank.sv
module tb_gauge_regbank;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] PF = 8'hA5;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00, stack_v = 8'h00;
  logic       bus_we = 1'b0, chg_pulse = 1'b0, dchg_pulse = 1'b0, dchg_start = 1'b0, edv1 = 1'b0;
  logic [7:0] bus_rdata;
  logic       chg_ctl_n, soft_rst;

  gauge_regbank #(.PROG_FULL(PF)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .stack_v(stack_v), .chg_pulse(chg_pulse), .dchg_pulse(dchg_pulse),
    .dchg_start(dchg_start), .edv1(edv1), .chg_ctl_n(chg_ctl_n), .soft_rst(soft_rst)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] m_limit, m_full, m_lcap, m_cap, m_corr, m_dcnt;
  logic [1:0] m_stat;
  logic m_fc, m_fd, m_arm, m_soft;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [7:0] a);
    case (a)
      8'h15: return m_limit;
      8'h18: return m_dcnt;
      8'h38: return {4'b0, m_fd, 2'b0, m_fc};
      8'h3F: return 8'hFF;
      8'h2E: return m_full;
      8'h0C: return m_lcap;
      8'h02: return m_cap;
      8'h0E: return m_corr;
      8'h0A: return {6'b0, m_stat};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h15: return "R1";
      8'h18: return "R3";
      8'h38: return "R6";
      8'h3F: return "R7";
      8'h39: return "R8";
      8'h2E, 8'h0C, 8'h02, 8'h0E, 8'h0A: return "R11";
      default: return "R13";
    endcase
  endfunction

  function automatic logic exp_ctl();
    logic [7:0] lim;
    lim = 8'(9'd256 - {1'b0, m_limit});
    return !(m_limit != 8'h00 && stack_v > lim);
  endfunction

  task automatic model_soft();
    m_limit = 0; m_cap = 0; m_corr = 0; m_stat = 2'b11; m_full = PF; m_lcap = PF; m_arm = 0;
  endtask

  task automatic model_update();
    logic fire;
    fire = bus_we && bus_addr == 8'h0C && bus_wdata == 0 && m_arm;
    if (fire) model_soft();
    else if (bus_we) begin
      m_arm = (bus_addr == 8'h2E && bus_wdata == 0);
      case (bus_addr)
        8'h15: m_limit = bus_wdata;
        8'h2E: m_full = bus_wdata;
        8'h0C: m_lcap = bus_wdata;
        8'h02: m_cap = bus_wdata;
        8'h0E: m_corr = bus_wdata;
        8'h0A: m_stat = bus_wdata[1:0];
        default: ;
      endcase
    end
    m_soft = fire;
    if (dchg_start) m_dcnt = 0;
    else if (dchg_pulse && !edv1 && m_dcnt != 8'hFF) m_dcnt = m_dcnt + 1;
    m_fc = chg_pulse  || (m_fc && !(bus_we && bus_addr == 8'h38 && !bus_wdata[0]));
    m_fd = dchg_pulse || (m_fd && !(bus_we && bus_addr == 8'h38 && !bus_wdata[3]));
  endtask

  task automatic cyc();
    #1;
    chk(tag_of(bus_addr), bus_rdata, exp_read(bus_addr));
    chk("R2", {7'b0, chg_ctl_n}, {7'b0, exp_ctl()});
    chk("R9", {7'b0, soft_rst}, {7'b0, m_soft});
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    bus_we = 0; chg_pulse = 0; dchg_pulse = 0; dchg_start = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    idle_inputs(); bus_we = 1; bus_addr = a; bus_wdata = d; cyc();
  endtask

  task automatic expect_rd(logic [7:0] a, logic [7:0] exp, string req);
    idle_inputs(); bus_addr = a;
    #1 chk(req, bus_rdata, exp);
    cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_dcnt = 0; m_fc = 0; m_fd = 0; m_soft = 0; model_soft();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 power-on values
    expect_rd(8'h15, 8'h00, "R12");
    expect_rd(8'h0C, PF, "R12");
    expect_rd(8'h2E, PF, "R12");
    expect_rd(8'h0A, 8'h03, "R12");
    expect_rd(8'h18, 8'h00, "R12");
    expect_rd(8'h38, 8'h00, "R12");
    expect_rd(8'h3F, 8'hFF, "R7");
    // R2 threshold boundary: C0h means limit 40h
    wr(8'h15, 8'hC0);
    stack_v = 8'h40; #1 chk("R2", {7'b0, chg_ctl_n}, 8'h01); cyc();
    stack_v = 8'h41; #1 chk("R2", {7'b0, chg_ctl_n}, 8'h00); cyc();
    // R7 write ignored
    wr(8'h3F, 8'h12);
    expect_rd(8'h3F, 8'hFF, "R7");
    // R8 reset register ignores writes
    wr(8'h39, 8'h5A);
    expect_rd(8'h15, 8'hC0, "R8");
    expect_rd(8'h39, 8'h00, "R8");
    // R4 saturation
    idle_inputs(); dchg_start = 1; cyc();
    for (int i = 0; i < 300; i++) begin idle_inputs(); dchg_pulse = 1; cyc(); end
    expect_rd(8'h18, 8'hFF, "R4");
    // R5 frozen by edv1
    idle_inputs(); dchg_start = 1; cyc();
    for (int i = 0; i < 5; i++) begin idle_inputs(); dchg_pulse = 1; cyc(); end
    edv1 = 1;
    for (int i = 0; i < 10; i++) begin idle_inputs(); dchg_pulse = 1; cyc(); end
    edv1 = 0;
    expect_rd(8'h18, 8'h05, "R5");
    // R6 sticky, write 1 keeps, write 0 clears, event wins
    idle_inputs(); chg_pulse = 1; dchg_pulse = 1; cyc();
    wr(8'h38, 8'hFF);
    expect_rd(8'h38, 8'h09, "R6");
    wr(8'h38, 8'h08);
    expect_rd(8'h38, 8'h08, "R6");
    idle_inputs(); bus_we = 1; bus_addr = 8'h38; bus_wdata = 8'h00; dchg_pulse = 1; cyc();
    expect_rd(8'h38, 8'h08, "R6");
    // R9 and R11 software reset
    wr(8'h02, 8'h07); wr(8'h0E, 8'h09); wr(8'h0A, 8'h00);
    wr(8'h2E, 8'h00); wr(8'h0C, 8'h00);
    chk("R9", {7'b0, soft_rst}, 8'h01);
    expect_rd(8'h15, 8'h00, "R11");
    expect_rd(8'h0C, PF, "R11");
    expect_rd(8'h0A, 8'h03, "R11");
    expect_rd(8'h02, 8'h00, "R11");
    expect_rd(8'h38, 8'h08, "R11");
    // R10 interrupted sequence
    wr(8'h2E, 8'h00); wr(8'h15, 8'h03); wr(8'h0C, 8'h00);
    chk("R10", {7'b0, soft_rst}, 8'h00);
    expect_rd(8'h0C, 8'h00, "R10");
    expect_rd(8'h15, 8'h03, "R10");
    wr(8'h2E, 8'h00); wr(8'h2E, 8'h04); wr(8'h0C, 8'h00);
    chk("R10", {7'b0, soft_rst}, 8'h00);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      logic [7:0] alist [12];
      alist = '{8'h15, 8'h18, 8'h38, 8'h39, 8'h3F, 8'h2E, 8'h0C, 8'h02, 8'h0E, 8'h0A, 8'h2E, 8'h0C};
      bus_addr   = ($urandom % 8 == 0) ? 8'($urandom) : alist[$urandom % 12];
      bus_we     = ($urandom % 2) == 0;
      bus_wdata  = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
      chg_pulse  = ($urandom % 5) == 0;
      dchg_pulse = ($urandom % 3) == 0;
      dchg_start = ($urandom % 200) == 0;
      if ($urandom % 10 == 0) edv1 = ~edv1;
      stack_v    = 8'($urandom);
      cyc();
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule